// File: doc/BRIEF.md
# Dual-Input Gated Up Counter with Snapshot Register

This block is a wide binary up counter fed by two alternative count inputs. A falling edge on either input adds one, but only while the other input sits low: holding one input high blocks all counting. A separate test input bumps only the upper half of the counter. It is accepted only while the lowest bit of that upper half is zero, so the upper half can be exercised without counting through the whole lower half. An active-low clear empties the counter.

A snapshot register beside the counter follows the counter while an active-low load strobe is held low. It keeps its last value once the strobe returns high, so software or a neighbouring block can read a stable value while counting goes on. All inputs are treated as asynchronous. Each one passes through a two-flop synchronizer, and edges are found by comparing consecutive synchronized samples on the single system clock.

Top module: `dual_gate_counter`

## Requirements
- R1: A falling edge on either count input, while the other count input is low, increments `count_o` by one. A rising edge never changes it.
- R2: While one count input is high, falling edges on the other count input are ignored and `count_o` keeps its value.
- R3: If both count inputs fall in the same cycle, the counter advances by exactly one.
- R4: While the synchronized `clr_n` is low, `count_o` becomes zero. The clear takes priority over every count and test edge.
- R5: A falling edge on `tst_cnt` adds one to the upper half of the counter (bits CNT_W-1 down to CNT_W/2) and leaves the lower half unchanged. It is accepted only when bit CNT_W/2 of the counter is 0 before that cycle's update.
- R6: A falling edge on `tst_cnt` while counter bit CNT_W/2 is 1 is ignored.
- R7: A normal count edge and an accepted test edge in the same cycle are both applied. The lower half increments first, and its carry and the test step both add to the upper half.
- R8: The counter wraps from all ones to all zeros.
- R9: While the synchronized `load_n` is low, `snap_o` takes, on every clock edge, the value that `count_o` takes on that same edge.
- R10: While the synchronized `load_n` is high, `snap_o` keeps its value.
- R11: A change on any input pin affects the registered outputs on the third rising clock edge after it is driven: two synchronizer stages, then the counter or snapshot register.
- R12: While `rst_n` is low, `count_o` and `snap_o` are zero, and no edge is seen on the count inputs when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr_n | input | 1 | Active-low counter clear (asynchronous pin, synchronized inside) |
| cnt_a | input | 1 | First count input; counts on falling edge; a high level blocks `cnt_b` |
| cnt_b | input | 1 | Second count input; counts on falling edge; a high level blocks `cnt_a` |
| tst_cnt | input | 1 | Test input that advances the upper half of the counter on its falling edge |
| load_n | input | 1 | Active-low snapshot strobe: the register follows while low and holds while high |
| count_o | output | CNT_W | Running counter value |
| snap_o | output | CNT_W | Snapshot register value |

## Verification
The bench builds the block with CNT_W = 8, so the upper half begins at bit 4 and a full wrap takes 256 pulses. At this width the all-ones-to-zero wrap, the carry out of the lower nibble meeting a test step in the same cycle, and the test gate closing when bit 4 is set are all reached within a short run. SYNC_STAGES keeps its default of 2, which fixes the three-edge input-to-output latency that the cycle-by-cycle model and the latency test depend on.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
   // positions of the asynchronous pins inside the synchronizer bank
   localparam int unsigned PIN_A    = 0;
   localparam int unsigned PIN_B    = 1;
   localparam int unsigned PIN_T    = 2;
   localparam int unsigned PIN_CLR  = 3;
   localparam int unsigned PIN_LD   = 4;
   localparam int unsigned PIN_N    = 5;
   // edge-sensitive pins occupy the low indices
   localparam int unsigned EDGE_N   = 3;
   // reset levels: count pins idle low (no false edge), clear and load inactive high
   localparam logic [PIN_N-1:0] PIN_RST = 5'b11000;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
   parameter int unsigned N      = 5,
   parameter int unsigned STAGES = 2,
   parameter logic [N-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] lvl_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sync_bank: STAGES must be at least 2");
   end
   if (N < 1) begin : g_bad_n
      $error("sync_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_pin
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST[i]}};
         else        chain <= {chain[STAGES-2:0], pin_i[i]};
      end
      assign lvl_o[i] = chain[STAGES-1];
   end
endmodule

// File: rtl/fall_detect.sv
module fall_detect #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] fall_o
);
   if (N < 1) begin : g_bad_n
      $error("fall_detect: N must be at least 1");
   end

   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/count_core.sv
module count_core #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         step_lo_i,
   input  logic         test_req_i,
   output logic         test_ok_o,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] cnt_next_o
);
   localparam int unsigned LOW_W = W / 2;
   localparam int unsigned HI_W  = W - LOW_W;

   if (W < 4 || (W % 2) != 0) begin : g_bad_w
      $error("count_core: W must be even and at least 4");
   end

   logic [W-1:0]    cnt_q;
   logic [LOW_W:0]  lo_sum;
   logic [HI_W-1:0] hi_sum;

   // test step gated on the lowest upper-half bit before this cycle's update
   assign test_ok_o = test_req_i & ~cnt_q[LOW_W];

   always_comb begin
      lo_sum = {1'b0, cnt_q[LOW_W-1:0]} + {{LOW_W{1'b0}}, step_lo_i};
      hi_sum = cnt_q[W-1:LOW_W]
             + {{(HI_W-1){1'b0}}, lo_sum[LOW_W]}
             + {{(HI_W-1){1'b0}}, test_ok_o};
      if (clear_i) cnt_next_o = '0;
      else         cnt_next_o = {hi_sum, lo_sum[LOW_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_next_o;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/snap_reg.sv
module snap_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("snap_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/dual_gate_counter.sv
module dual_gate_counter #(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             cnt_a,
   input  logic             cnt_b,
   input  logic             tst_cnt,
   input  logic             load_n,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] snap_o
);
   import dgc_pkg::*;

   if (CNT_W < 4 || (CNT_W % 2) != 0) begin : g_bad_w
      $error("dual_gate_counter: CNT_W must be even and at least 4");
   end

   logic [PIN_N-1:0]  pins, lvl;
   logic [EDGE_N-1:0] fall;
   logic              a_lvl, b_lvl, clr_lvl, load_lvl;
   logic              a_fall, b_fall, t_fall;
   logic              step_lo, test_ok;
   logic [CNT_W-1:0]  cnt_q, cnt_d, snap_q;

   always_comb begin
      pins          = '0;
      pins[PIN_A]   = cnt_a;
      pins[PIN_B]   = cnt_b;
      pins[PIN_T]   = tst_cnt;
      pins[PIN_CLR] = clr_n;
      pins[PIN_LD]  = load_n;
   end

   sync_bank #(
      .N(PIN_N), .STAGES(SYNC_STAGES), .RST(PIN_RST)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .lvl_o(lvl)
   );

   fall_detect #(.N(EDGE_N)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl[EDGE_N-1:0]), .fall_o(fall)
   );

   assign a_lvl    = lvl[PIN_A];
   assign b_lvl    = lvl[PIN_B];
   assign clr_lvl  = lvl[PIN_CLR];
   assign load_lvl = lvl[PIN_LD];
   assign a_fall   = fall[PIN_A];
   assign b_fall   = fall[PIN_B];
   assign t_fall   = fall[PIN_T];

   // a high level on one input blocks the other; simultaneous falls give one step
   assign step_lo = (a_fall & ~b_lvl) | (b_fall & ~a_lvl);

   count_core #(.W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .clear_i(~clr_lvl), .step_lo_i(step_lo),
      .test_req_i(t_fall), .test_ok_o(test_ok), .cnt_o(cnt_q), .cnt_next_o(cnt_d)
   );

   snap_reg #(.W(CNT_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .load_i(~load_lvl), .d_i(cnt_d), .q_o(snap_q)
   );

   assign count_o = cnt_q;
   assign snap_o  = snap_q;
endmodule

// File: rtl/dual_gate_counter_chk.sv
module dual_gate_counter_chk #(
   parameter int unsigned W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clr_lvl,
   input logic         load_lvl,
   input logic         a_fall,
   input logic         b_fall,
   input logic         b_lvl,
   input logic         t_fall,
   input logic         step_lo,
   input logic         test_ok,
   input logic [W-1:0] cnt_q,
   input logic [W-1:0] snap_q
);
   localparam int unsigned LOW_W = W / 2;

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_lvl |=> (cnt_q == '0)); // R4

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_lo && clr_lvl && !test_ok) |=> (cnt_q == $past(cnt_q) + W'(1))); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_lo && !test_ok && clr_lvl) |=> $stable(cnt_q)); // R1

   AST_INHIBIT_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (a_fall && b_lvl && !b_fall && !t_fall && clr_lvl) |=> $stable(cnt_q)); // R2

   AST_TEST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (t_fall && cnt_q[LOW_W] && !step_lo && clr_lvl) |=> $stable(cnt_q)); // R6

   AST_SNAP_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      !load_lvl |=> (snap_q == cnt_q)); // R9

   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      load_lvl |=> $stable(snap_q)); // R10

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (cnt_q == '0 && snap_q == '0); // R12
      end
   end
endmodule

bind dual_gate_counter dual_gate_counter_chk #(.W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_lvl(clr_lvl), .load_lvl(load_lvl),
   .a_fall(a_fall), .b_fall(b_fall), .b_lvl(b_lvl), .t_fall(t_fall),
   .step_lo(step_lo), .test_ok(test_ok), .cnt_q(cnt_q), .snap_q(snap_q)
);

// File: tb/dual_gate_counter_test.sv
`timescale 1ns/1ps
module dual_gate_counter_test;
   localparam int unsigned W   = 8;
   localparam int unsigned LOW = W / 2;
   localparam int unsigned NV  = 14;

   // vector: [12]=load_n [11]=clr_n [10]=tst [9]=b [8]=a, [7:0]=cycles held
   localparam logic [12:0] VEC [NV] = '{
      {5'b11000, 8'd3}, {5'b11001, 8'd2}, {5'b11000, 8'd3},
      {5'b11010, 8'd2}, {5'b11000, 8'd3}, {5'b11011, 8'd3},
      {5'b11010, 8'd3}, {5'b11000, 8'd3}, {5'b11100, 8'd2},
      {5'b01000, 8'd4}, {5'b01001, 8'd2}, {5'b01000, 8'd3},
      {5'b10001, 8'd3}, {5'b11000, 8'd5}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] drv = 5'b11000;
   logic [W-1:0] count_o, snap_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit cmp_on = 1'b0;

   always #2 clk = ~clk;

   dual_gate_counter #(.CNT_W(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .clr_n(drv[3]), .cnt_a(drv[0]), .cnt_b(drv[1]),
      .tst_cnt(drv[2]), .load_n(drv[4]), .count_o(count_o), .snap_o(snap_o)
   );

   // reference model: inputs reach the decision point two edges after being driven (R11)
   logic [4:0]   q1, q2, q3;
   logic [W-1:0] m_cnt, m_snap;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q1 = 5'b11000; q2 = 5'b11000; q3 = 5'b11000;
         m_cnt = '0; m_snap = '0;
      end else begin
         logic [4:0] fl;
         logic inc, tok;
         logic [W-1:0] nx;
         fl  = q3 & ~q2;
         inc = (fl[0] & ~q2[1]) | (fl[1] & ~q2[0]);
         tok = fl[2] & ~m_cnt[LOW];
         nx  = m_cnt + W'(inc);
         if (tok) nx = nx + W'(1 << LOW);
         if (!q2[3]) nx = '0;
         m_cnt = nx;
         if (!q2[4]) m_snap = nx;
         q3 = q2; q2 = q1; q1 = drv;
      end
   end

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         check("R1/model count", count_o, m_cnt);
         check("R9/model snapshot", snap_o, m_snap);
      end
   end

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_a();
      drv[0] = 1'b1; waitn(2); drv[0] = 1'b0; waitn(2);
   endtask

   task automatic pulse_b();
      drv[1] = 1'b1; waitn(2); drv[1] = 1'b0; waitn(2);
   endtask

   task automatic clear_cnt();
      drv[3] = 1'b0; waitn(4); drv[3] = 1'b1; waitn(3);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      waitn(4);
      check("R12 reset count", count_o, '0);
      check("R12 reset snapshot", snap_o, '0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      waitn(3);
      check("R12 no edge after reset", count_o, '0);

      // table walk, compared against the model on every cycle
      for (int i = 0; i < NV; i++) begin
         drv = VEC[i][12:8];
         waitn(int'(VEC[i][7:0]));
      end
      waitn(4);

      // directed tests
      clear_cnt();
      check("R4 clear", count_o, 8'd0);

      repeat (5) pulse_a();
      waitn(3);
      check("R1 five falls on cnt_a", count_o, 8'd5);

      drv[0] = 1'b1; waitn(3);
      repeat (3) pulse_b();
      waitn(3);
      check("R2 cnt_b blocked by high cnt_a", count_o, 8'd5);
      drv[0] = 1'b0; waitn(4);
      check("R1 cnt_a fall with cnt_b low", count_o, 8'd6);

      drv[1:0] = 2'b11; waitn(3);
      drv[1:0] = 2'b00; waitn(4);
      check("R3 simultaneous falls", count_o, 8'd7);

      drv[2] = 1'b1; waitn(2); drv[2] = 1'b0; waitn(4);
      check("R5 test step upper half", count_o, 8'd23);
      drv[2] = 1'b1; waitn(2); drv[2] = 1'b0; waitn(4);
      check("R6 test step blocked by bit set", count_o, 8'd23);

      clear_cnt();
      repeat (15) pulse_a();
      waitn(3);
      check("R7 setup lower half full", count_o, 8'd15);
      drv[2] = 1'b1; drv[0] = 1'b1; waitn(3);
      drv[2] = 1'b0; drv[0] = 1'b0; waitn(4);
      check("R7 carry and test together", count_o, 8'd32);

      drv[4] = 1'b0; waitn(4);
      check("R9 snapshot follows", snap_o, 8'd32);
      drv[4] = 1'b1; waitn(3);
      repeat (2) pulse_a();
      waitn(3);
      check("R10 count moves on", count_o, 8'd34);
      check("R10 snapshot held", snap_o, 8'd32);

      drv[3] = 1'b0; drv[0] = 1'b1; waitn(2);
      drv[0] = 1'b0; waitn(4);
      check("R4 clear beats count", count_o, 8'd0);
      drv[3] = 1'b1; waitn(3);
      check("R4 stays zero after release", count_o, 8'd0);

      drv[0] = 1'b1; waitn(4);
      drv[0] = 1'b0;
      waitn(1);
      check("R11 one edge later", count_o, 8'd0);
      waitn(1);
      check("R11 two edges later", count_o, 8'd0);
      waitn(1);
      check("R11 three edges later", count_o, 8'd1);

      clear_cnt();
      repeat (255) pulse_a();
      waitn(3);
      check("R8 all ones", count_o, 8'd255);
      pulse_a();
      waitn(3);
      check("R8 wrap to zero", count_o, 8'd0);

      waitn(2);
      done = 1'b1;
      finish_run();
   end
endmodule